// File: doc/BRIEF.md
# Flash Status Polling Completion Controller

This block sits on the host side of a parallel flash device. It decides when a program or erase started by a separate command sequencer has finished. Once the last write of the command sequence has completed, the sequencer pulses `start` with the operation type, the address to poll and the word that was written. The controller then reads that address over and over through a synchronous read port. In each reply it looks only at the status bit, bit 7 of the returned word. For a program it compares that bit with bit 7 of the written word. For an erase it waits for the bit to become 1.

The status bit can settle before the other data bits do. For that reason, once it first shows its final value, the controller issues one more read and reports the word from that read. Each operation ends with a one-cycle result that gives a completion code and the word read. A program result also carries a flag that is set when the word read back differs from the one written, which happens when a protected sector left the array unchanged. A poll budget, loaded at start, bounds the wait. A suspend request seen during an erase changes the completion code from "done" to "suspended".

Top module: `dpoll_ctrl`

## Requirements
- R1: After reset, `busy`, `rd_valid` and `res_valid` are 0.
- R2: `start` is taken only while `busy` is 0. A `start` while busy does not change the polled address or the result of the running operation.
- R3: Every read goes to `op_addr` captured at start. A status read counts as "true" when bit 7 of `rd_rdata` equals bit 7 of `op_data` for a program (`op_erase`=0), or equals 1 for an erase (`op_erase`=1). Otherwise it counts as busy.
- R4: After the first true status read, exactly one more read is issued. `res_data` is the word returned by that confirming read, not the word returned by the status read.
- R5: At most one read is outstanding. A read is accepted in a cycle where `rd_valid` and `rd_ready` are both 1, and its data is on `rd_rdata` in the next cycle. While `rd_ready` is 0, `rd_valid` stays 1 and `rd_addr` stays stable.
- R6: The result is a one-cycle `res_valid` pulse, during which `busy` is already 0. `res_code` is 0 for done, 1 for suspended and 2 for timeout.
- R7: If the number of busy status reads reaches `max_polls` (a value of 0 acts as 1), the controller reports code 2 with the last word read and returns to idle. No confirming read is made.
- R8: If `suspend_req` is 1 in any cycle of the polling phase of an erase, the completion is reported as code 1. For a program, `suspend_req` has no effect.
- R9: For a program, `res_mismatch` is 1 when the confirming word differs from `op_data`. For an erase, and for any timeout, it is 0.
- R10: A busy phase of any length below `max_polls` reads, for example several hundred reads, completes with code 0 and does not time out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin polling. Taken only while idle |
| op_erase | input | 1 | 1 = erase, 0 = program |
| op_addr | input | AW | Address to poll |
| op_data | input | DW | Word written by the program operation |
| max_polls | input | CW | Budget of busy status reads |
| suspend_req | input | 1 | Suspend was issued to the device |
| rd_valid | output | 1 | Read request |
| rd_ready | input | 1 | Read port accepts the request |
| rd_addr | output | AW | Read address |
| rd_rdata | input | DW | Read data, one cycle after acceptance |
| busy | output | 1 | An operation is in progress |
| res_valid | output | 1 | One-cycle result strobe |
| res_code | output | 2 | 0 done, 1 suspended, 2 timeout |
| res_data | output | DW | Word from the final read |
| res_mismatch | output | 1 | Program readback differed from `op_data` |

## Verification
The hardest case to reach from the ports is a status bit that has already flipped while the other bits of the same word are still stale. A controller that reports the status read itself would look correct against any memory model that returns one value per address. To cover it, the bench's read responder follows a per-vector script: a number of busy words, then one "early" word whose bit 7 is final but whose other bits are wrong, then the final word. The reported data must equal the final word, and the read count must show that exactly one confirming read was made. The same scripted responder also throttles `rd_ready` in several patterns, to hold requests waiting during both the status phase and the confirm phase.

// File: rtl/dpoll_pkg.sv
package dpoll_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_POLL  = 3'd1,
        ST_PWAIT = 3'd2,
        ST_CONF  = 3'd3,
        ST_CWAIT = 3'd4
    } dp_state_e;

    typedef enum logic [1:0] {
        RES_DONE = 2'd0,
        RES_SUSP = 2'd1,
        RES_TMO  = 2'd2
    } dp_res_e;

endpackage

// File: rtl/dpoll_judge.sv
module dpoll_judge #(
    parameter int DW       = 16,
    parameter int STAT_BIT = 7
) (
    input  logic [DW-1:0] rdata,
    input  logic          erase,
    input  logic [DW-1:0] exp_word,
    output logic          stat_true,
    output logic          word_match
);

    logic exp_bit;

    always_comb begin
        exp_bit    = erase ? 1'b1 : exp_word[STAT_BIT];
        stat_true  = (rdata[STAT_BIT] == exp_bit);
        word_match = (rdata == exp_word);
    end

endmodule

// File: rtl/dpoll_budget.sv
module dpoll_budget #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic [CW-1:0] limit,
    input  logic          tick,
    output logic          expire
);

    localparam int XW = CW + 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [CW-1:0] lim;
    } bud_t;

    bud_t q, d;
    logic [XW-1:0] lim_eff;
    logic [XW-1:0] next_cnt;

    always_comb begin
        d        = q;
        lim_eff  = (q.lim == '0) ? XW'(1) : {1'b0, q.lim};
        next_cnt = {1'b0, q.cnt} + XW'(1);
        expire   = tick && (next_cnt >= lim_eff);
        if (clear) begin
            d.cnt = '0;
            d.lim = limit;
        end else if (tick && !expire) begin
            d.cnt = next_cnt[CW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // R7: a busy poll never finds the count already past the budget
    p_within_budget_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> ({1'b0, q.cnt} < lim_eff));

endmodule

// File: rtl/dpoll_ctrl.sv
module dpoll_ctrl
    import dpoll_pkg::*;
#(
    parameter int AW       = 20,
    parameter int DW       = 16,
    parameter int CW       = 16,
    parameter int STAT_BIT = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          op_erase,
    input  logic [AW-1:0] op_addr,
    input  logic [DW-1:0] op_data,
    input  logic [CW-1:0] max_polls,
    input  logic          suspend_req,
    output logic          rd_valid,
    input  logic          rd_ready,
    output logic [AW-1:0] rd_addr,
    input  logic [DW-1:0] rd_rdata,
    output logic          busy,
    output logic          res_valid,
    output logic [1:0]    res_code,
    output logic [DW-1:0] res_data,
    output logic          res_mismatch
);

    localparam bit STAT_OK = (STAT_BIT < DW);

    typedef struct packed {
        dp_state_e     st;
        logic          erase;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic          susp;
        logic          res_valid;
        dp_res_e       res_code;
        logic [DW-1:0] res_data;
        logic          res_mism;
    } ctl_t;

    ctl_t q, d;
    logic stat_true, word_match;
    logic bud_clear, bud_tick, bud_expire;
    logic polling;

    generate
        if (!STAT_OK) begin : g_bad_stat
            initial $error("STAT_BIT lies outside the data word");
        end
    endgenerate

    dpoll_judge #(
        .DW      (DW),
        .STAT_BIT(STAT_BIT)
    ) u_judge (
        .rdata     (rd_rdata),
        .erase     (q.erase),
        .exp_word  (q.data),
        .stat_true (stat_true),
        .word_match(word_match)
    );

    dpoll_budget #(
        .CW(CW)
    ) u_budget (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (bud_clear),
        .limit (max_polls),
        .tick  (bud_tick),
        .expire(bud_expire)
    );

    always_comb begin
        d           = q;
        d.res_valid = 1'b0;
        rd_valid    = 1'b0;
        bud_clear   = 1'b0;
        bud_tick    = 1'b0;
        polling     = (q.st == ST_POLL) || (q.st == ST_PWAIT);

        unique case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.st      = ST_POLL;
                    d.erase   = op_erase;
                    d.addr    = op_addr;
                    d.data    = op_data;
                    d.susp    = 1'b0;
                    bud_clear = 1'b1;
                end
            end
            ST_POLL: begin
                rd_valid = 1'b1;
                if (rd_ready) d.st = ST_PWAIT;
            end
            ST_PWAIT: begin
                if (stat_true) begin
                    d.st = ST_CONF;
                end else begin
                    bud_tick = 1'b1;
                    if (bud_expire) begin
                        d.st        = ST_IDLE;
                        d.res_valid = 1'b1;
                        d.res_code  = RES_TMO;
                        d.res_data  = rd_rdata;
                        d.res_mism  = 1'b0;
                    end else begin
                        d.st = ST_POLL;
                    end
                end
            end
            ST_CONF: begin
                rd_valid = 1'b1;
                if (rd_ready) d.st = ST_CWAIT;
            end
            ST_CWAIT: begin
                d.st        = ST_IDLE;
                d.res_valid = 1'b1;
                d.res_code  = (q.erase && q.susp) ? RES_SUSP : RES_DONE;
                d.res_data  = rd_rdata;
                d.res_mism  = !q.erase && !word_match;
            end
            default: d.st = ST_IDLE;
        endcase

        if (polling && q.erase && suspend_req) d.susp = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st        <= ST_IDLE;
            q.erase     <= 1'b0;
            q.addr      <= '0;
            q.data      <= '0;
            q.susp      <= 1'b0;
            q.res_valid <= 1'b0;
            q.res_code  <= RES_DONE;
            q.res_data  <= '0;
            q.res_mism  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign rd_addr      = q.addr;
    assign busy         = (q.st != ST_IDLE);
    assign res_valid    = q.res_valid;
    assign res_code     = q.res_code;
    assign res_data     = q.res_data;
    assign res_mismatch = q.res_mism;

    // R5: a waiting request holds its address until accepted
    p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));

    // R5: an accepted read is followed by a cycle with no request
    p_single_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_ready) |=> !rd_valid);

    // R6: result strobe lasts one cycle
    p_res_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    // R6: controller is idle while the result is shown
    p_res_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !busy);

    // R2: a start during an operation leaves the polled address alone
    p_start_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(rd_addr));

    // R8: a suspended completion only comes from an erase
    p_susp_erase_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_code == RES_SUSP) |-> q.erase);

    // R9: a mismatch is only flagged on a completed program
    p_mism_program_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_mismatch) |-> (!q.erase && res_code == RES_DONE));

endmodule

// File: tb/test_dpoll_ctrl.sv
module test_dpoll_ctrl;

    localparam int AW = 20;
    localparam int DW = 16;
    localparam int CW = 16;

    typedef struct packed {
        logic          erase;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic [15:0]   nbusy;
        logic [DW-1:0] busyw;
        logic [DW-1:0] earlyw;
        logic [DW-1:0] finalw;
        logic [CW-1:0] maxp;
        logic          susp;
        logic [1:0]    rmode;
        logic [1:0]    ecode;
        logic [DW-1:0] edata;
        logic          emism;
        logic [15:0]   ereads;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        // R3 R4 program, bit7=1, early word has stale low bits
        '{1'b0, 20'h01234, 16'hA5C3, 16'd3,   16'h0043, 16'h00C3, 16'hA5C3, 16'd10,  1'b0, 2'd0, 2'd0, 16'hA5C3, 1'b0, 16'd5},
        // R3 R5 program, bit7=0, throttled port
        '{1'b0, 20'h00F0F, 16'h1234, 16'd0,   16'h00B4, 16'h0034, 16'h1234, 16'd4,   1'b0, 2'd1, 2'd0, 16'h1234, 1'b0, 16'd2},
        // R9 program into protected sector
        '{1'b0, 20'h7FFFF, 16'h00FF, 16'd2,   16'h0000, 16'hFFFF, 16'hFFFF, 16'd6,   1'b0, 2'd0, 2'd0, 16'hFFFF, 1'b1, 16'd4},
        // R3 R4 erase, slow port
        '{1'b1, 20'h40000, 16'h0000, 16'd5,   16'h0000, 16'h00FF, 16'hFFFF, 16'd20,  1'b0, 2'd2, 2'd0, 16'hFFFF, 1'b0, 16'd7},
        // R8 erase suspended
        '{1'b1, 20'h40010, 16'h0000, 16'd4,   16'h0040, 16'h0080, 16'hFFFF, 16'd20,  1'b1, 2'd0, 2'd1, 16'hFFFF, 1'b0, 16'd6},
        // R8 program ignores suspend
        '{1'b0, 20'h00100, 16'h0080, 16'd3,   16'h0000, 16'h0080, 16'h0080, 16'd8,   1'b1, 2'd0, 2'd0, 16'h0080, 1'b0, 16'd5},
        // R7 timeout on program
        '{1'b0, 20'h00200, 16'h0080, 16'd6,   16'h5A00, 16'h0080, 16'h0080, 16'd3,   1'b0, 2'd1, 2'd2, 16'h5A00, 1'b0, 16'd3},
        // R7 zero budget acts as one
        '{1'b1, 20'h00300, 16'h0000, 16'd2,   16'h0000, 16'hFFFF, 16'hFFFF, 16'd0,   1'b0, 2'd0, 2'd2, 16'h0000, 1'b0, 16'd1},
        // R10 long busy phase
        '{1'b1, 20'h12345, 16'h0000, 16'd299, 16'h0000, 16'h0080, 16'hFFFF, 16'd300, 1'b0, 2'd0, 2'd0, 16'hFFFF, 1'b0, 16'd301},
        // R7 boundary: busy reads equal budget
        '{1'b1, 20'h00400, 16'h0000, 16'd5,   16'h0011, 16'hFFFF, 16'hFFFF, 16'd5,   1'b0, 2'd2, 2'd2, 16'h0011, 1'b0, 16'd5},
        // R9 erase never flags mismatch
        '{1'b1, 20'h00500, 16'h1234, 16'd1,   16'h0000, 16'h00F0, 16'h00F0, 16'd5,   1'b0, 2'd0, 2'd0, 16'h00F0, 1'b0, 16'd3}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          op_erase = 1'b0;
    logic [AW-1:0] op_addr = '0;
    logic [DW-1:0] op_data = '0;
    logic [CW-1:0] max_polls = '0;
    logic          suspend_req = 1'b0;
    logic          rd_valid;
    logic          rd_ready = 1'b0;
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] rd_rdata = '0;
    logic          busy;
    logic          res_valid;
    logic [1:0]    res_code;
    logic [DW-1:0] res_data;
    logic          res_mismatch;

    int n_chk = 0;
    int n_bad = 0;

    // scripted read responder state
    int            m_nbusy = 0;
    logic [DW-1:0] m_busyw = '0, m_earlyw = '0, m_finalw = '0;
    logic [1:0]    m_mode = 2'd0;
    int            m_idx = 0;
    int            m_rcnt = 0;
    logic [AW-1:0] m_exp_addr = '0;
    logic          m_bad_addr = 1'b0;

    always #2 clk = ~clk;

    dpoll_ctrl #(.AW(AW), .DW(DW), .CW(CW)) i_dpoll_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .op_erase    (op_erase),
        .op_addr     (op_addr),
        .op_data     (op_data),
        .max_polls   (max_polls),
        .suspend_req (suspend_req),
        .rd_valid    (rd_valid),
        .rd_ready    (rd_ready),
        .rd_addr     (rd_addr),
        .rd_rdata    (rd_rdata),
        .busy        (busy),
        .res_valid   (res_valid),
        .res_code    (res_code),
        .res_data    (res_data),
        .res_mismatch(res_mismatch)
    );

    // responder: decides readiness and supplies data at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            m_rcnt++;
            case (m_mode)
                2'd1:    rd_ready = (m_rcnt % 2) == 0;
                2'd2:    rd_ready = (m_rcnt % 3) == 0;
                default: rd_ready = 1'b1;
            endcase
            if (rd_valid && rd_ready) begin
                if (rd_addr !== m_exp_addr) m_bad_addr = 1'b1;
                if (m_idx < m_nbusy)       rd_rdata = m_busyw;
                else if (m_idx == m_nbusy) rd_rdata = m_earlyw;
                else                       rd_rdata = m_finalw;
                m_idx++;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic arm(input vec_t v);
        m_nbusy    = int'(v.nbusy);
        m_busyw    = v.busyw;
        m_earlyw   = v.earlyw;
        m_finalw   = v.finalw;
        m_mode     = v.rmode;
        m_idx      = 0;
        m_exp_addr = v.addr;
        m_bad_addr = 1'b0;
    endtask

    // returns 1 when res_valid was seen
    task automatic run_op(input vec_t v, input bit stray_start, output bit seen);
        arm(v);
        op_erase  = v.erase;
        op_addr   = v.addr;
        op_data   = v.data;
        max_polls = v.maxp;
        start     = 1'b1;
        @(negedge clk);
        start     = 1'b0;
        seen      = 1'b0;
        for (int j = 0; j < 5000; j++) begin
            if (res_valid) begin
                seen = 1'b1;
                break;
            end
            if (j == 1) suspend_req = v.susp;
            if (j == 2) begin
                suspend_req = 1'b0;
                if (stray_start) begin
                    op_erase = ~v.erase;
                    op_addr  = v.addr ^ 20'h00FFF;
                    op_data  = ~v.data;
                    start    = 1'b1;
                end
            end
            if (j == 3) start = 1'b0;
            @(negedge clk);
        end
        suspend_req = 1'b0;
        start       = 1'b0;
    endtask

    task automatic judge(input vec_t v, input string req, input bit seen);
        check(seen, req, "result seen", 32'(seen), 32'd1);
        check(res_code == v.ecode, req, "res_code", 32'(res_code), 32'(v.ecode));
        check(res_data == v.edata, req, "res_data", 32'(res_data), 32'(v.edata));
        check(res_mismatch == v.emism, req, "res_mismatch", 32'(res_mismatch), 32'(v.emism));
        check(m_idx == int'(v.ereads), req, "read count", 32'(m_idx), 32'(v.ereads));
        check(!m_bad_addr, req, "read address", 32'(m_bad_addr), 32'd0);
        check(!busy, "R6", "busy with result", 32'(busy), 32'd0);
        @(negedge clk);
        check(!res_valid, "R6", "strobe width", 32'(res_valid), 32'd0);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        bit seen;
        vec_t dv;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!busy, "R1", "busy", 32'(busy), 32'd0);
        check(!rd_valid, "R1", "rd_valid", 32'(rd_valid), 32'd0);
        check(!res_valid, "R1", "res_valid", 32'(res_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            run_op(VECS[i], 1'b0, seen);
            judge(VECS[i], $sformatf("vec%0d", i), seen);
            repeat (2) @(negedge clk);
        end

        // R2 start while busy is ignored
        dv = VECS[0];
        dv.nbusy  = 16'd6;
        dv.ereads = 16'd8;
        run_op(dv, 1'b1, seen);
        judge(dv, "R2", seen);

        // R1 reset mid-operation returns to idle
        dv = VECS[3];
        arm(dv);
        op_erase = dv.erase; op_addr = dv.addr; max_polls = dv.maxp;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(!busy && !rd_valid, "R1", "idle after reset", 32'({busy, rd_valid}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule